// File: doc/BRIEF.md
# Pin Controller with Sticky Level-Match Interrupts

This block manages a bank of general-purpose pins. For each pin, software picks whether the pin stays a plain I/O or is handed to an alternate-function peripheral. It also picks whether the pin drives or listens, and the value it drives. It can read back the live, synchronized level of every pin. Register accesses arrive as requests on a valid/ready channel. A read returns its word on a separate valid/ready response channel.

Each pin also has a programmable trigger level. Whenever the synchronized pin equals that level, the pin's status bit is set. The bit then stays set until software clears it, even if the pin moves away. A per-pin enable steers each status bit to the non-maskable interrupt output. Status bits of pins without that enable feed the ordinary interrupt output, but only while the pin is in plain I/O mode.

Top module: `gpio_lvl_ctrl`

## Requirements
- R1: After reset the function, direction, drive and enable registers are all zero and the trigger-level register is all ones. Status is empty, and `irq_o`, `nmi_o` and `pad_oe_o` are low.
- R2: `alt_sel_o` equals the function register; a pin with its function bit at 1 never has its output enable asserted.
- R3: `pad_oe_o` is the direction bit (1 = output) gated by plain I/O mode, and `pad_out_o` follows the drive register.
- R4: Reading offset 0x08 returns the pin inputs after a two-flop synchronizer, not the drive register.
- R5: A status bit is set on the clock after the synchronized pin equals its trigger-level bit.
- R6: Status bits are sticky. A write to offset 0x10 clears bits written 0 and keeps bits written 1, and a match in the same cycle wins over the clear.
- R7: `nmi_o` is high exactly when some status bit has its NMI enable bit set.
- R8: `irq_o` is high exactly when some status bit has its NMI enable at 0 and its function bit at 0.
- R9: Register offsets (address bits [4:2]): 0x00 function, 0x04 direction, 0x08 data, 0x0C trigger level, 0x10 status, 0x14 NMI enable. Written registers read back what was written; offsets 0x18 and 0x1C read 0 and ignore writes.
- R10: A request transfers when `req_valid_i` and `req_ready_o` are both high. `req_ready_o` is low while a read response is pending, and a response holds `rsp_valid_o` and `rsp_data_o` steady until `rsp_ready_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Register request valid |
| req_ready_o | output | 1 | Register request ready |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 5 | Byte offset |
| req_wdata_i | input | NPINS | Write data, one bit per pin |
| rsp_valid_o | output | 1 | Read response valid |
| rsp_ready_i | input | 1 | Read response ready |
| rsp_data_o | output | NPINS | Read data |
| pad_in_i | input | NPINS | Asynchronous pin inputs |
| pad_out_o | output | NPINS | Pin drive values |
| pad_oe_o | output | NPINS | Pin output enables |
| alt_sel_o | output | NPINS | Alternate-function select per pin |
| irq_o | output | 1 | Ordinary interrupt |
| nmi_o | output | 1 | Non-maskable interrupt |

## Verification
The bench builds the block with `NPINS = 4`, so every pin and level pattern fits in a 4-bit word. Every pin pattern is swept against every trigger level, and every function pattern against every direction pattern. With four pins, the interrupt routing across the enable and function combinations can also be checked exhaustively. The small width keeps these full sweeps within a few thousand cycles, while the sticky, clear-mask and back-pressure cases are driven directly.

// File: rtl/gpio_lvl_pkg.sv
package gpio_lvl_pkg;
  typedef enum logic [2:0] {
    REG_FUNC  = 3'd0,
    REG_DIR   = 3'd1,
    REG_DATA  = 3'd2,
    REG_LVL   = 3'd3,
    REG_STAT  = 3'd4,
    REG_NMIEN = 3'd5
  } reg_idx_e;
  localparam int ADDR_W = 5;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_q, out_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        out_q  <= 1'b0;
      end else begin
        meta_q <= d[i];
        out_q  <= meta_q;
      end
    end
    assign q[i] = out_q;
  end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_lvl_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [NPINS-1:0]  req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [NPINS-1:0]  rsp_data,
  input  logic [NPINS-1:0]  pin_sync,
  input  logic [NPINS-1:0]  stat_q,
  output logic [NPINS-1:0]  func_q,
  output logic [NPINS-1:0]  dir_q,
  output logic [NPINS-1:0]  drv_q,
  output logic [NPINS-1:0]  lvl_q,
  output logic [NPINS-1:0]  nmien_q,
  output logic              clr_en,
  output logic [NPINS-1:0]  clr_keep
);
  logic       take;
  logic       wr;
  reg_idx_e   idx;
  logic [NPINS-1:0] rd_word;

  assign req_ready = !rsp_valid;
  assign take      = req_valid && req_ready;
  assign wr        = take && req_write;
  assign idx       = reg_idx_e'(req_addr[ADDR_W-1:2]);
  assign clr_en    = wr && (idx == REG_STAT);
  assign clr_keep  = req_wdata;

  always_comb begin
    case (idx)
      REG_FUNC:  rd_word = func_q;
      REG_DIR:   rd_word = dir_q;
      REG_DATA:  rd_word = pin_sync;
      REG_LVL:   rd_word = lvl_q;
      REG_STAT:  rd_word = stat_q;
      REG_NMIEN: rd_word = nmien_q;
      default:   rd_word = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      func_q  <= '0;
      dir_q   <= '0;
      drv_q   <= '0;
      lvl_q   <= '1;
      nmien_q <= '0;
    end else if (wr) begin
      case (idx)
        REG_FUNC:  func_q  <= req_wdata;
        REG_DIR:   dir_q   <= req_wdata;
        REG_DATA:  drv_q   <= req_wdata;
        REG_LVL:   lvl_q   <= req_wdata;
        REG_NMIEN: nmien_q <= req_wdata;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (take && !req_write) begin
      rsp_valid <= 1'b1;
      rsp_data  <= rd_word;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/gpio_irq.sv
module gpio_irq #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_sync,
  input  logic [NPINS-1:0] lvl_q,
  input  logic [NPINS-1:0] func_q,
  input  logic [NPINS-1:0] nmien_q,
  input  logic             clr_en,
  input  logic [NPINS-1:0] clr_keep,
  output logic [NPINS-1:0] stat_q,
  output logic             irq,
  output logic             nmi
);
  logic [NPINS-1:0] hit;
  logic [NPINS-1:0] kept;

  assign hit  = ~(pin_sync ^ lvl_q);
  assign kept = clr_en ? (stat_q & clr_keep) : stat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= kept | hit;
  end

  assign nmi = |(stat_q & nmien_q);
  assign irq = |(stat_q & ~nmien_q & ~func_q);
endmodule

// File: rtl/gpio_lvl_ctrl.sv
module gpio_lvl_ctrl
  import gpio_lvl_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [NPINS-1:0]  req_wdata_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic [NPINS-1:0]  rsp_data_o,
  input  logic [NPINS-1:0]  pad_in_i,
  output logic [NPINS-1:0]  pad_out_o,
  output logic [NPINS-1:0]  pad_oe_o,
  output logic [NPINS-1:0]  alt_sel_o,
  output logic              irq_o,
  output logic              nmi_o
);
  logic [NPINS-1:0] pin_sync, stat_q, func_q, dir_q, drv_q, lvl_q, nmien_q, clr_keep;
  logic             clr_en;

  gpio_sync #(.W(NPINS)) sync_i (
    .clk(clk), .rst_n(rst_n), .d(pad_in_i), .q(pin_sync)
  );

  gpio_regs #(.NPINS(NPINS)) regs_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid_i), .req_ready(req_ready_o), .req_write(req_write_i),
    .req_addr(req_addr_i), .req_wdata(req_wdata_i),
    .rsp_valid(rsp_valid_o), .rsp_ready(rsp_ready_i), .rsp_data(rsp_data_o),
    .pin_sync(pin_sync), .stat_q(stat_q),
    .func_q(func_q), .dir_q(dir_q), .drv_q(drv_q), .lvl_q(lvl_q), .nmien_q(nmien_q),
    .clr_en(clr_en), .clr_keep(clr_keep)
  );

  gpio_irq #(.NPINS(NPINS)) irq_i (
    .clk(clk), .rst_n(rst_n), .pin_sync(pin_sync), .lvl_q(lvl_q),
    .func_q(func_q), .nmien_q(nmien_q), .clr_en(clr_en), .clr_keep(clr_keep),
    .stat_q(stat_q), .irq(irq_o), .nmi(nmi_o)
  );

  assign pad_out_o = drv_q;
  assign pad_oe_o  = dir_q & ~func_q;
  assign alt_sel_o = func_q;
endmodule

// File: rtl/gpio_lvl_chk.sv
module gpio_lvl_chk #(
  parameter int NPINS = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPINS-1:0] pin_sync,
  input logic [NPINS-1:0] lvl_q,
  input logic [NPINS-1:0] stat_q,
  input logic [NPINS-1:0] nmien_q,
  input logic [NPINS-1:0] func_q,
  input logic             clr_en,
  input logic             irq_o,
  input logic             nmi_o,
  input logic [NPINS-1:0] pad_oe_o,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [NPINS-1:0] rsp_data
);
  assert_match_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & $past(~(pin_sync ^ lvl_q))) == $past(~(pin_sync ^ lvl_q))));

  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_en |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  assert_nmi_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & nmien_q) == '0) |-> !nmi_o);

  assert_irq_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & ~nmien_q & ~func_q) == '0) |-> !irq_o);

  assert_alt_no_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe_o & func_q) == '0);

  assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
endmodule

bind gpio_lvl_ctrl gpio_lvl_chk #(.NPINS(NPINS)) chk_i (
  .clk(clk), .rst_n(rst_n), .pin_sync(pin_sync), .lvl_q(lvl_q), .stat_q(stat_q),
  .nmien_q(nmien_q), .func_q(func_q), .clr_en(clr_en), .irq_o(irq_o), .nmi_o(nmi_o),
  .pad_oe_o(pad_oe_o), .rsp_valid(rsp_valid_o), .rsp_ready(rsp_ready_i),
  .rsp_data(rsp_data_o)
);

// File: tb/gpio_lvl_ctrl_tb.sv
module gpio_lvl_ctrl_tb_top;
  localparam int N = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [4:0] req_addr = '0;
  logic [N-1:0] req_wdata = '0, pad_in = '0;
  logic req_ready, rsp_valid, irq, nmi;
  logic [N-1:0] rsp_data, pad_out, pad_oe, alt_sel;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  gpio_lvl_ctrl #(.NPINS(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_write_i(req_write), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready), .rsp_data_o(rsp_data),
    .pad_in_i(pad_in), .pad_out_o(pad_out), .pad_oe_o(pad_oe), .alt_sel_o(alt_sel),
    .irq_o(irq), .nmi_o(nmi)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [N-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [N-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    d = rsp_data;
    @(negedge clk);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [N-1:0] v, hold;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    // R1: reset values
    rd(5'h00, v); chk("R1 func", v, 0);
    rd(5'h04, v); chk("R1 dir", v, 0);
    rd(5'h0C, v); chk("R1 level", v, 4'hF);
    rd(5'h10, v); chk("R1 status", v, 0);
    rd(5'h14, v); chk("R1 nmien", v, 0);
    chk("R1 irq", irq, 0); chk("R1 nmi", nmi, 0); chk("R1 oe", pad_oe, 0);

    // R9: readback and unmapped offsets
    wr(5'h00, 4'h9); rd(5'h00, v); chk("R9 func rb", v, 4'h9);
    wr(5'h04, 4'h6); rd(5'h04, v); chk("R9 dir rb", v, 4'h6);
    wr(5'h14, 4'h0); rd(5'h14, v); chk("R9 nmien rb", v, 0);
    wr(5'h18, 4'hF); rd(5'h18, v); chk("R9 unmapped 18", v, 0);
    wr(5'h1C, 4'hF); rd(5'h1C, v); chk("R9 unmapped 1C", v, 0);
    rd(5'h00, v); chk("R9 func untouched", v, 4'h9);
    rd(5'h04, v); chk("R9 dir untouched", v, 4'h6);

    // R2/R3: exhaustive function x direction, drive follows data register
    for (int f = 0; f < 16; f++) begin
      wr(5'h00, f[N-1:0]);
      for (int c = 0; c < 16; c++) begin
        wr(5'h04, c[N-1:0]);
        wr(5'h08, c[N-1:0] ^ 4'h5);
        chk("R3 oe", pad_oe, c & ~f & 4'hF);
        chk("R3 out", pad_out, (c ^ 5) & 4'hF);
        chk("R2 alt", alt_sel, f);
      end
    end
    wr(5'h00, 0); wr(5'h04, 0);

    // R4: data read returns synchronized pins, not the drive latch
    wr(5'h08, 4'hA);
    for (int p = 0; p < 16; p++) begin
      pad_in = p[N-1:0];
      settle();
      rd(5'h08, v); chk("R4 pin read", v, p);
    end

    // R5/R6/R8: exhaustive pin x level, clear with zeros, match re-sets
    for (int l = 0; l < 16; l++) begin
      wr(5'h0C, l[N-1:0]);
      for (int p = 0; p < 16; p++) begin
        pad_in = p[N-1:0];
        settle();
        wr(5'h10, 4'h0);
        rd(5'h10, v);
        chk("R5 R6 match after clear", v, ~(p ^ l) & 4'hF);
        chk("R8 irq", irq, ((~(p ^ l) & 4'hF) != 0));
      end
    end

    // R6: stickiness and clear mask
    wr(5'h0C, 4'hF); pad_in = 4'h0; settle(); wr(5'h10, 4'h0);
    rd(5'h10, v); chk("R6 cleared", v, 0);
    pad_in = 4'hF; settle(); pad_in = 4'h0; settle();
    rd(5'h10, v); chk("R6 sticky", v, 4'hF);
    wr(5'h10, 4'h5); rd(5'h10, v); chk("R6 keep ones", v, 4'h5);

    // R7/R8: routing across enables and function bits
    wr(5'h14, 4'h3);
    chk("R7 nmi", nmi, 1); chk("R8 irq bit2", irq, 1);
    wr(5'h00, 4'h4); chk("R8 irq gated by func", irq, 0); chk("R7 nmi func", nmi, 1);
    wr(5'h00, 4'h0); wr(5'h10, 4'h1);
    chk("R7 nmi bit0", nmi, 1); chk("R8 irq none", irq, 0);
    wr(5'h14, 4'h0); chk("R7 nmi off", nmi, 0); chk("R8 irq on", irq, 1);
    wr(5'h10, 4'h0); chk("R8 irq cleared", irq, 0);

    // R10: back-pressure on the response
    pad_in = 4'h6; settle();
    rsp_ready = 1'b0;
    @(negedge clk); req_valid = 1'b1; req_write = 1'b0; req_addr = 5'h08;
    @(negedge clk); req_valid = 1'b0;
    chk("R10 rsp valid", rsp_valid, 1);
    hold = rsp_data;
    chk("R10 rsp data", hold, 4'h6);
    pad_in = 4'h1;
    repeat (5) @(negedge clk);
    chk("R10 held valid", rsp_valid, 1);
    chk("R10 held data", rsp_data, hold);
    chk("R10 not ready", req_ready, 0);
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R10 released", rsp_valid, 0);
    chk("R10 ready again", req_ready, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule